// File: doc/BRIEF.md
# Subscription-Wakeup Issue Queue

This block is the shared scheduling window of a small two-wide out-of-order pipeline. It holds sixteen waiting instructions. It replaces the usual tag-compare wakeup with direct indexing. Every entry keeps two subscriber slots. A consumer that dispatches while one of its producers is still waiting writes its own entry index and operand number into a free subscriber slot of that producer. When the producer is picked for issue, it reads its own slots and sets the listed ready bits. No comparator array is needed.

The rename stage supplies, for each source, a busy flag and the queue index of the producing entry. That index is kept in a per-register field next to the rename map. Up to two instructions enter per cycle, and they take the lowest free indices. Up to two ready instructions leave per cycle, on the lanes that the execution side permits. The choice among ready entries comes from a rotating scan whose start point is set by a free-running LFSR, so it does not follow age. A flush empties the whole window in one cycle.

Top module: `subq_top`

## Requirements
- R1: After reset no entry is valid and nothing issues. A first pair of dispatch requests is granted into entries 0 (lane 0) and 1 (lane 1).
- R2: A source operand is ready at dispatch if its busy flag is 0, if the named producer entry is not valid, or if that producer issues in the same cycle. Only otherwise does the dispatch take a subscriber slot of the producer.
- R3: Lane 0 is granted when it requests, no flush is asserted, at least one entry is free and its subscriptions fit. It is written into the lowest-numbered free entry, and that index is reported on its slot output.
- R4: Lane 1 is granted only together with lane 0, when a second free entry exists and the subscriptions of both lanes fit together. It takes the second-lowest free entry.
- R5: A producer has two subscriber slots, and two sources that name the same producer take two slots. A dispatch that would need more slots than remain is not granted. It stays stalled until that producer issues.
- R6: An entry issues only when it is valid, both its operands are ready and its lane's allow input is 1. Two issues in one cycle name different entries. The number issued is the smaller of the allowed lane count and the ready entry count.
- R7: A subscribed operand becomes ready in the cycle after its producer issues, so a consumer issues at the earliest one cycle after its producer.
- R8: The tag written at dispatch appears on the issue tag output when the entry issues. The entry is free again from the next cycle.
- R9: While flush is 1 nothing is granted and nothing issues. In the next cycle every entry is free, with no ready bits and no subscriptions left.
- R10: Selection is not lowest-index-first. When three or more entries are ready, lane 0 sometimes picks an entry other than the lowest-numbered ready one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every entry |
| disp_req | input | 2 | Dispatch request per lane |
| disp_busy | input | 2x2 | Per lane and source: the source has an in-flight producer |
| disp_prod | input | 2x2x4 | Per lane and source: queue index of that producer |
| disp_tag | input | 2x8 | Per lane: instruction tag to store |
| disp_grant | output | 2 | Per lane: dispatch accepted this cycle |
| disp_slot | output | 2x4 | Per lane: entry index allocated |
| iss_allow | input | 2 | Per lane: execution side can take an instruction |
| iss_valid | output | 2 | Per lane: an instruction issues |
| iss_slot | output | 2x4 | Per lane: index of the issuing entry |
| iss_tag | output | 2x8 | Per lane: tag of the issuing entry |

## Verification
A lost or misdirected subscription leaves a consumer's ready bit clear. That consumer never issues, so the issue count falls below the ready count predicted by the model within a few cycles, or a later dispatch gets a wrong lowest-free index. An early ready bit shows as a consumer issuing in the same cycle as its producer. A wrong count of free subscriber slots shows on the very next dispatch that names that producer, as a grant that should have stalled or a stall that should have been granted.

// File: rtl/subq_pkg.sv
package subq_pkg;
    localparam int NQ    = 16;
    localparam int QW    = $clog2(NQ);
    localparam int NSUB  = 2;
    localparam int RW    = $clog2(NSUB + 1);
    localparam int TAG_W = 8;
    localparam int LANES = 2;
    localparam int NSRC  = 2;
    localparam int LFSR_W = 16;

    typedef logic [QW-1:0] qidx_t;

    typedef struct packed {
        logic  used;
        qidx_t who;
        logic  opnd;
    } sub_t;

    typedef struct packed {
        logic             live;
        logic [NSRC-1:0]  rdy;
        sub_t [NSUB-1:0]  subs;
        logic [TAG_W-1:0] tag;
    } ent_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/subq_alloc.sv
module subq_alloc
    import subq_pkg::*;
(
    input  logic [NQ-1:0]          live,
    output logic [LANES-1:0]       have,
    output qidx_t [LANES-1:0]      pick
);
    logic [NQ-1:0] taken;

    always_comb begin
        taken = live;
        for (int l = 0; l < LANES; l++) begin
            have[l] = 1'b0;
            pick[l] = '0;
            for (int e = 0; e < NQ; e++) begin
                if (!have[l] && !taken[e]) begin
                    have[l] = 1'b1;
                    pick[l] = QW'(e);
                end
            end
            if (have[l]) taken[pick[l]] = 1'b1;
        end
    end
endmodule

// File: rtl/subq_pick.sv
module subq_pick
    import subq_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NQ-1:0]      elig,
    input  logic [LANES-1:0]   allow,
    output logic [LANES-1:0]   fire,
    output qidx_t [LANES-1:0]  slot
);
    logic [LFSR_W-1:0] st;
    qidx_t             off;
    qidx_t             c;
    logic [NQ-1:0]     taken;

    always_ff @(posedge clk) begin
        if (rst) st <= SEED;
        else     st <= lfsr_step(st);
    end

    assign off = st[QW-1:0];

    always_comb begin
        taken = '0;
        c = '0;
        for (int l = 0; l < LANES; l++) begin
            fire[l] = 1'b0;
            slot[l] = '0;
            if (allow[l]) begin
                for (int k = 0; k < NQ; k++) begin
                    c = (l % 2 == 0) ? off + QW'(k) : off - QW'(k);
                    if (!fire[l] && elig[c] && !taken[c]) begin
                        fire[l] = 1'b1;
                        slot[l] = c;
                    end
                end
            end
            if (fire[l]) taken[slot[l]] = 1'b1;
        end
    end
endmodule

// File: rtl/subq_subcap.sv
module subq_subcap
    import subq_pkg::*;
(
    input  logic [NQ-1:0][RW-1:0]          room,
    input  logic [LANES-1:0][NSRC-1:0]     sreq,
    input  qidx_t [LANES-1:0][NSRC-1:0]    sprod,
    output logic [LANES-1:0]               fits
);
    int acc;

    always_comb begin
        fits = '1;
        acc  = 0;
        for (int e = 0; e < NQ; e++) begin
            acc = 0;
            for (int l = 0; l < LANES; l++) begin
                for (int o = 0; o < NSRC; o++) begin
                    if (sreq[l][o] && sprod[l][o] == QW'(e)) acc = acc + 1;
                end
                if (acc > int'(room[e])) fits[l] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/subq_top.sv
module subq_top
    import subq_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               flush,
    input  logic [LANES-1:0]                   disp_req,
    input  logic [LANES-1:0][NSRC-1:0]         disp_busy,
    input  logic [LANES-1:0][NSRC-1:0][QW-1:0] disp_prod,
    input  logic [LANES-1:0][TAG_W-1:0]        disp_tag,
    output logic [LANES-1:0]                   disp_grant,
    output logic [LANES-1:0][QW-1:0]           disp_slot,
    input  logic [LANES-1:0]                   iss_allow,
    output logic [LANES-1:0]                   iss_valid,
    output logic [LANES-1:0][QW-1:0]           iss_slot,
    output logic [LANES-1:0][TAG_W-1:0]        iss_tag
);
    ent_t q    [NQ];
    ent_t q_nx [NQ];

    logic [NQ-1:0]             live, elig, hit;
    logic [NQ-1:0][RW-1:0]     room;
    logic [LANES-1:0][NSRC-1:0] sreq;
    logic [LANES-1:0]          have, fits, fire, allow_g;
    qidx_t [LANES-1:0]         apick, ipick;
    qidx_t [LANES-1:0][NSRC-1:0] prod_q;
    qidx_t                     p;
    logic                      placed;

    always_comb begin
        for (int e = 0; e < NQ; e++) begin
            live[e] = q[e].live;
            elig[e] = q[e].live & (&q[e].rdy);
            room[e] = '0;
            for (int s = 0; s < NSUB; s++)
                if (!q[e].subs[s].used) room[e] = room[e] + RW'(1);
        end
    end

    assign allow_g = iss_allow & ~{LANES{flush}};

    subq_pick #(.SEED(SEED)) u_pick (
        .clk(clk), .rst(rst), .elig(elig), .allow(allow_g),
        .fire(fire), .slot(ipick)
    );

    subq_alloc u_alloc (.live(live), .have(have), .pick(apick));

    always_comb begin
        hit = '0;
        for (int l = 0; l < LANES; l++) if (fire[l]) hit[ipick[l]] = 1'b1;
        for (int l = 0; l < LANES; l++)
            for (int o = 0; o < NSRC; o++) begin
                prod_q[l][o] = disp_prod[l][o];
                sreq[l][o] = disp_req[l] & disp_busy[l][o]
                           & live[disp_prod[l][o]] & ~hit[disp_prod[l][o]];
            end
    end

    subq_subcap u_cap (.room(room), .sreq(sreq), .sprod(prod_q), .fits(fits));

    always_comb begin
        disp_grant[0] = disp_req[0] & have[0] & fits[0] & ~flush;
        for (int l = 1; l < LANES; l++)
            disp_grant[l] = disp_grant[l-1] & disp_req[l] & have[l] & fits[l];
        for (int l = 0; l < LANES; l++) begin
            disp_slot[l] = apick[l];
            iss_valid[l] = fire[l];
            iss_slot[l]  = ipick[l];
            iss_tag[l]   = q[ipick[l]].tag;
        end
    end

    always_comb begin
        p = '0;
        placed = 1'b0;
        for (int e = 0; e < NQ; e++) q_nx[e] = q[e];
        // wakeup through subscriber slots, then release the issuing entry
        for (int l = 0; l < LANES; l++) begin
            if (fire[l]) begin
                for (int s = 0; s < NSUB; s++)
                    if (q[ipick[l]].subs[s].used)
                        q_nx[q[ipick[l]].subs[s].who].rdy[q[ipick[l]].subs[s].opnd] = 1'b1;
            end
        end
        for (int l = 0; l < LANES; l++) begin
            if (fire[l]) begin
                q_nx[ipick[l]].live = 1'b0;
                q_nx[ipick[l]].subs = '0;
            end
        end
        // new entries
        for (int l = 0; l < LANES; l++) begin
            if (disp_grant[l]) begin
                q_nx[apick[l]].live = 1'b1;
                q_nx[apick[l]].tag  = disp_tag[l];
                q_nx[apick[l]].subs = '0;
                for (int o = 0; o < NSRC; o++) q_nx[apick[l]].rdy[o] = ~sreq[l][o];
            end
        end
        // subscriptions into producers
        for (int l = 0; l < LANES; l++) begin
            for (int o = 0; o < NSRC; o++) begin
                if (disp_grant[l] && sreq[l][o]) begin
                    p = disp_prod[l][o];
                    placed = 1'b0;
                    for (int s = 0; s < NSUB; s++) begin
                        if (!placed && !q_nx[p].subs[s].used) begin
                            q_nx[p].subs[s] = '{used: 1'b1, who: apick[l], opnd: 1'(o)};
                            placed = 1'b1;
                        end
                    end
                end
            end
        end
        if (flush) for (int e = 0; e < NQ; e++) q_nx[e] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) for (int e = 0; e < NQ; e++) q[e] <= '0;
        else     for (int e = 0; e < NQ; e++) q[e] <= q_nx[e];
    end

    // R6: two issues name different entries
    assert_pair_distinct_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid[0] && iss_valid[1]) |-> (iss_slot[0] != iss_slot[1]));
    // R6: an issuing entry is valid and fully ready, on a permitted lane
    assert_issue_ready_R6: assert property (@(posedge clk) disable iff (rst)
        iss_valid[0] |-> (q[iss_slot[0]].live && (&q[iss_slot[0]].rdy) && iss_allow[0]));
    assert_issue_ready1_R6: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> (q[iss_slot[1]].live && (&q[iss_slot[1]].rdy) && iss_allow[1]));
    // R4: lane 1 never enters without lane 0
    assert_lane_order_R4: assert property (@(posedge clk) disable iff (rst)
        disp_grant[1] |-> disp_grant[0]);
    // R3: allocation only into a free entry
    assert_alloc_free_R3: assert property (@(posedge clk) disable iff (rst)
        disp_grant[0] |-> !q[disp_slot[0]].live);
    // R8: an issued entry is free in the following cycle
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        iss_valid[0] |=> !q[$past(iss_slot[0])].live);
    // R9: flush empties the window
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (live == '0));
endmodule

// File: tb/tb_subq_top.sv
module tb_subq_top;
    import subq_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic [1:0]           disp_req = '0;
    logic [1:0][1:0]      disp_busy = '0;
    logic [1:0][1:0][3:0] disp_prod = '0;
    logic [1:0][7:0]      disp_tag = '0;
    logic [1:0]           disp_grant;
    logic [1:0][3:0]      disp_slot;
    logic [1:0]           iss_allow = '0;
    logic [1:0]           iss_valid;
    logic [1:0][3:0]      iss_slot;
    logic [1:0][7:0]      iss_tag;

    always #(CLK_P/2) clk = ~clk;

    subq_top dut (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_req(disp_req), .disp_busy(disp_busy), .disp_prod(disp_prod),
        .disp_tag(disp_tag), .disp_grant(disp_grant), .disp_slot(disp_slot),
        .iss_allow(iss_allow), .iss_valid(iss_valid), .iss_slot(iss_slot),
        .iss_tag(iss_tag)
    );

    int checks = 0;
    int errors = 0;
    int nonlow = 0;
    bit done = 0;

    bit m_live [NQ];
    bit m_rdy  [NQ][2];
    int m_wait [NQ][2];
    int m_tag  [NQ];

    logic [1:0] obs_grant, obs_iss;
    int obs_slot0;

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int e = 0; e < NQ; e++) begin
            m_live[e] = 0; m_tag[e] = 0;
            for (int o = 0; o < 2; o++) begin m_rdy[e][o] = 0; m_wait[e][o] = -1; end
        end
    endtask

    function automatic int waiters(int p);
        int n = 0;
        for (int e = 0; e < NQ; e++)
            for (int o = 0; o < 2; o++)
                if (m_live[e] && m_wait[e][o] == p) n++;
        return n;
    endfunction

    task automatic evaluate();
        bit is_iss [NQ];
        bit sq [2][2];
        int nready, nallow, nexp, ncnt, lowrdy, lo0, lo1, nfree, n0, n1;
        bit g0, g1, f0, f1;
        for (int e = 0; e < NQ; e++) is_iss[e] = 0;
        nready = 0; lowrdy = -1;
        for (int e = 0; e < NQ; e++)
            if (m_live[e] && m_rdy[e][0] && m_rdy[e][1]) begin
                nready++;
                if (lowrdy < 0) lowrdy = e;
            end
        nallow = flush ? 0 : (int'(iss_allow[0]) + int'(iss_allow[1]));
        nexp = (nallow < nready) ? nallow : nready;
        ncnt = 0;
        for (int l = 0; l < 2; l++) begin
            if (iss_valid[l]) begin
                ncnt++;
                chk(iss_allow[l] && !flush, "R6 issue on a permitted lane", l, -1);
                chk(m_live[iss_slot[l]] && m_rdy[iss_slot[l]][0] && m_rdy[iss_slot[l]][1],
                    "R7 issued entry must be ready", int'(iss_slot[l]), -1);
                chk(int'(iss_tag[l]) == m_tag[iss_slot[l]], "R8 issue tag",
                    int'(iss_tag[l]), m_tag[iss_slot[l]]);
                is_iss[iss_slot[l]] = 1;
            end
        end
        if (iss_valid == 2'b11)
            chk(iss_slot[0] != iss_slot[1], "R6 distinct issue slots",
                int'(iss_slot[1]), -1);
        chk(ncnt == nexp, "R6 issue count", ncnt, nexp);
        if (nready >= 3 && iss_valid[0] && int'(iss_slot[0]) != lowrdy) nonlow++;

        lo0 = -1; lo1 = -1; nfree = 0;
        for (int e = 0; e < NQ; e++)
            if (!m_live[e]) begin
                nfree++;
                if (lo0 < 0) lo0 = e; else if (lo1 < 0) lo1 = e;
            end
        for (int l = 0; l < 2; l++)
            for (int o = 0; o < 2; o++)
                sq[l][o] = disp_req[l] && disp_busy[l][o] && m_live[disp_prod[l][o]]
                           && !is_iss[disp_prod[l][o]];
        f0 = 1; f1 = 1;
        for (int p = 0; p < NQ; p++) begin
            n0 = 0; n1 = 0;
            for (int o = 0; o < 2; o++) begin
                if (sq[0][o] && int'(disp_prod[0][o]) == p) n0++;
                if (sq[1][o] && int'(disp_prod[1][o]) == p) n1++;
            end
            if (n0 > 2 - waiters(p)) f0 = 0;
            if (n0 + n1 > 2 - waiters(p)) f1 = 0;
        end
        g0 = !flush && disp_req[0] && nfree >= 1 && f0;
        g1 = g0 && disp_req[1] && nfree >= 2 && f1;
        chk(disp_grant[0] == g0, "R3 lane0 grant", int'(disp_grant[0]), int'(g0));
        chk(disp_grant[1] == g1, "R4 lane1 grant", int'(disp_grant[1]), int'(g1));
        if (g0 && disp_grant[0])
            chk(int'(disp_slot[0]) == lo0, "R3 lane0 slot", int'(disp_slot[0]), lo0);
        if (g1 && disp_grant[1])
            chk(int'(disp_slot[1]) == lo1, "R4 lane1 slot", int'(disp_slot[1]), lo1);
        obs_grant = disp_grant; obs_iss = iss_valid; obs_slot0 = int'(disp_slot[0]);

        if (flush) model_clear();
        else begin
            for (int i = 0; i < NQ; i++) begin
                if (is_iss[i]) begin
                    for (int e = 0; e < NQ; e++)
                        for (int o = 0; o < 2; o++)
                            if (m_live[e] && m_wait[e][o] == i) begin
                                m_rdy[e][o] = 1; m_wait[e][o] = -1;
                            end
                    m_live[i] = 0;
                end
            end
            for (int l = 0; l < 2; l++) begin
                if ((l == 0) ? g0 : g1) begin
                    int e;
                    e = (l == 0) ? lo0 : lo1;
                    m_live[e] = 1;
                    m_tag[e] = int'(disp_tag[l]);
                    for (int o = 0; o < 2; o++) begin
                        m_rdy[e][o]  = !sq[l][o];
                        m_wait[e][o] = sq[l][o] ? int'(disp_prod[l][o]) : -1;
                    end
                end
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        evaluate();
        @(posedge clk);
        #1;
    endtask

    task automatic set_lane(int l, bit rq, bit b0, int p0, bit b1, int p1, int tg);
        disp_req[l] = rq;
        disp_busy[l][0] = b0; disp_prod[l][0] = 4'(p0);
        disp_busy[l][1] = b1; disp_prod[l][1] = 4'(p1);
        disp_tag[l] = 8'(tg);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset, first pair lands in 0 and 1
        iss_allow = 2'b00;
        set_lane(0, 1, 0, 0, 0, 0, 11);
        set_lane(1, 1, 0, 0, 0, 0, 12);
        step();
        chk(obs_iss == 2'b00, "R1 no issue after reset", int'(obs_iss), 0);
        chk(obs_grant == 2'b11 && obs_slot0 == 0, "R1 first pair granted", obs_slot0, 0);

        // R5: lane0 takes both slots of entry 0, lane1 overflows
        set_lane(0, 1, 1, 0, 1, 0, 13);
        set_lane(1, 1, 1, 0, 0, 0, 14);
        step();
        chk(obs_grant == 2'b01, "R5 lane1 stalls on full subscriber slots", int'(obs_grant), 1);

        // R5: lane0 now stalls as well
        set_lane(0, 1, 1, 0, 0, 0, 14);
        set_lane(1, 0, 0, 0, 0, 0, 0);
        step();
        chk(obs_grant == 2'b00, "R5 dispatch stalled while producer waits", int'(obs_grant), 0);

        // R2: producer issues this cycle, consumer enters with operand ready
        iss_allow = 2'b11;
        step();
        chk(obs_iss == 2'b11, "R6 both ready entries issue", int'(obs_iss), 3);
        chk(obs_grant == 2'b01 && obs_slot0 == 3, "R2 same-cycle producer counts as done",
            obs_slot0, 3);

        // R7: woken consumers issue one cycle after the producer
        set_lane(0, 0, 0, 0, 0, 0, 0);
        step();
        chk(obs_iss == 2'b11, "R7 woken consumers issue next cycle", int'(obs_iss), 3);

        // R9: flush
        iss_allow = 2'b00;
        set_lane(0, 1, 0, 0, 0, 0, 21);
        set_lane(1, 1, 0, 0, 0, 0, 22);
        step();
        step();
        flush = 1'b1;
        step();
        chk(obs_grant == 2'b00 && obs_iss == 2'b00, "R9 nothing moves during flush",
            int'(obs_grant), 0);
        flush = 1'b0;
        step();
        chk(obs_grant == 2'b11 && obs_slot0 == 0, "R9 window empty after flush", obs_slot0, 0);

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            for (int l = 0; l < 2; l++)
                set_lane(l, ($urandom % 4) != 0, $urandom % 2, $urandom % NQ,
                         $urandom % 2, $urandom % NQ, $urandom % 256);
            iss_allow = 2'($urandom % 4);
            flush = ($urandom % 150) == 0;
            step();
        end
        flush = 1'b0;

        chk(nonlow > 0, "R10 selection not lowest-first", nonlow, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule